// File: doc/BRIEF.md
# ULPI Link-Side Register Access Engine

This block sits on the link side of an 8-bit ULPI bus, in the 60 MHz ULPI clock domain, and carries out register reads and writes in a transceiver. Local logic hands it one request at a time through a valid/ready port: direction, register address and, for a write, the data byte. When the bus transaction finishes, it reports completion with a single-cycle pulse. For a read, the same pulse carries the returned byte.

An address that fits the 6-bit command field goes inside the command byte, which is immediate addressing. When the extended-addressing configuration input is high, addresses at or above the reserved escape code are sent differently. The command then carries the escape code and a separate address byte follows it. The transceiver may take the bus by raising DIR while the link is driving a command, address or data byte. It may also report a receive event in place of register data. In either case the engine releases the bus, waits for DIR to drop, and restarts the whole operation from its first byte. It repeats this until the operation completes. The requester sees only the final completion.

The request port applies back-pressure with `req_ready`. It is high only while the engine is idle and DIR is low, and a request transfers on a cycle where `req_valid` and `req_ready` are both high. The completion port has no back-pressure. `rsp_valid` is a one-cycle pulse and must be consumed when seen.

Top module: `ulpi_reg_link`

## Requirements
- R1: `req_ready` is high only when no operation is in progress and `ulpi_dir` is low. A `req_valid` presented while `ulpi_dir` is high starts nothing, and the link keeps driving 0x00.
- R2: An immediate write drives the command byte {2'b10, addr[5:0]} and then the data byte. Each byte stays on `ulpi_data_o` until a cycle in which `ulpi_nxt` is high.
- R3: Extended form is used when `ext_addr_en` is 1 and the address is 0x2F or higher. In that case the command's low six bits are 6'b101111 and the full 8-bit address follows as its own byte before any data. In every other case the command carries addr[5:0] and the upper address bits are ignored.
- R4: In the cycle after the final write data byte is accepted, `ulpi_stp` is high for exactly one clock with `ulpi_data_o` at 0x00. `rsp_valid` pulses in the following cycle.
- R5: A read drives the command byte {2'b11, addr[5:0]} (or its extended form with the address byte). It then drives 0x00 until DIR rises. The first cycle with DIR high is a turnaround, and `ulpi_data_i` is sampled in the next cycle.
- R6: A read completes when DIR is seen low after the data cycle. `rsp_valid` is then high for one cycle with `rsp_rdata` equal to the sampled byte.
- R7: If DIR is high while a command, address or data byte is being driven, `ulpi_data_oe` goes low in that same cycle and the operation is abandoned.
- R8: After an abandon, the first byte of the original command is driven again in the cycle after DIR is seen low. No new request is accepted in between.
- R9: If `ulpi_nxt` is high in a read's data cycle, the cycle is a receive event. The byte is discarded and the read is retried as in R8.
- R10: After reset the link is idle. It drives 0x00 with `ulpi_data_oe` high, `ulpi_stp` low and `rsp_valid` low, and `req_ready` is high if DIR is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ULPI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_addr_en | input | 1 | Enables extended addressing for high addresses |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_valid for reads |
| ulpi_dir | input | 1 | Bus direction from the transceiver |
| ulpi_nxt | input | 1 | Byte-accept / receive strobe from the transceiver |
| ulpi_data_i | input | 8 | Bus data from the transceiver |
| ulpi_data_o | output | 8 | Bus data driven by the link |
| ulpi_data_oe | output | 1 | Link output enable for the data bus |
| ulpi_stp | output | 1 | Stop strobe |

## Verification
The assertions assume the transceiver obeys the bus protocol. It raises NXT only for a byte the link is driving, or during a data cycle to signal a receive event. It holds DIR high across a read's turnaround and data cycle, and it never raises DIR in the same cycle as the stop strobe. The bench's transceiver model only ever changes DIR and NXT at falling clock edges, in states where those moves are legal. It injects bus takeovers on the command byte, on the address or data byte, and as NXT in the read data cycle. In every case it lowers DIR before the retry is expected.

// File: rtl/ulpi_reg_pkg.sv
package ulpi_reg_pkg;

  // command type prefixes for the two top bits of a transmit command
  localparam logic [1:0] CMD_PFX_WRITE = 2'b10;
  localparam logic [1:0] CMD_PFX_READ  = 2'b11;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_WDATA,
    ST_STP,
    ST_RWAIT,
    ST_RDATA,
    ST_RHOLD,
    ST_ABORT
  } ulpi_st_e;

endpackage

// File: rtl/ulpi_req_hold.sv
module ulpi_req_hold #(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-3:0] EXT_CODE = 'h2F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              ext_addr_en,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              op_write,
  output logic              op_ext,
  output logic [DATA_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_wdata
);

  localparam int unsigned FIELD_W = DATA_W - 2;

  logic use_ext;

  // extended form only above the escape code and only when enabled
  always_comb begin
    use_ext = ext_addr_en && (req_addr >= {{(DATA_W-FIELD_W){1'b0}}, EXT_CODE});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_write <= 1'b0;
      op_ext   <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
    end else if (accept) begin
      op_write <= req_write;
      op_ext   <= use_ext;
      op_addr  <= req_addr;
      op_wdata <= req_wdata;
    end
  end

endmodule

// File: rtl/ulpi_reg_fsm.sv
module ulpi_reg_fsm
  import ulpi_reg_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              op_write,
  input  logic              op_ext,
  input  logic              ulpi_dir,
  input  logic              ulpi_nxt,
  input  logic [DATA_W-1:0] ulpi_data_i,
  output ulpi_st_e          state,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  ulpi_st_e st_q, st_d;
  logic     done_d;
  logic     cap_en;

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    cap_en = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (accept) st_d = ST_CMD;
      ST_CMD: begin
        if (ulpi_dir)       st_d = ST_ABORT;
        else if (ulpi_nxt)  st_d = op_ext ? ST_ADDR : (op_write ? ST_WDATA : ST_RWAIT);
      end
      ST_ADDR: begin
        if (ulpi_dir)       st_d = ST_ABORT;
        else if (ulpi_nxt)  st_d = op_write ? ST_WDATA : ST_RWAIT;
      end
      ST_WDATA: begin
        if (ulpi_dir)       st_d = ST_ABORT;
        else if (ulpi_nxt)  st_d = ST_STP;
      end
      ST_STP: begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
      // first cycle with DIR high is the turnaround
      ST_RWAIT: if (ulpi_dir) st_d = ST_RDATA;
      ST_RDATA: begin
        if (!ulpi_dir || ulpi_nxt) st_d = ST_ABORT;
        else begin
          st_d   = ST_RHOLD;
          cap_en = 1'b1;
        end
      end
      ST_RHOLD: begin
        if (!ulpi_dir) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      ST_ABORT: if (!ulpi_dir) st_d = ST_CMD;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      st_q      <= st_d;
      rsp_valid <= done_d;
      if (cap_en) rsp_rdata <= ulpi_data_i;
    end
  end

  assign state = st_q;

  // R7
  abort_on_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_CMD || st_q == ST_ADDR || st_q == ST_WDATA) && ulpi_dir) |=> (st_q == ST_ABORT));

  // R8
  retry_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_ABORT && st_q != ST_ABORT) |-> (st_q == ST_CMD));

  // R5
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RDATA) |-> ($past(st_q) == ST_RWAIT && $past(ulpi_dir)));

  // R6
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/ulpi_bus_drive.sv
module ulpi_bus_drive
  import ulpi_reg_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-3:0] EXT_CODE = 'h2F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ulpi_st_e          state,
  input  logic              op_write,
  input  logic              op_ext,
  input  logic [DATA_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_wdata,
  input  logic              ulpi_dir,
  output logic [DATA_W-1:0] ulpi_data_o,
  output logic              ulpi_data_oe,
  output logic              ulpi_stp
);

  logic [DATA_W-1:0] cmd_byte;
  logic [DATA_W-3:0] cmd_field;
  logic              link_owns;

  always_comb begin
    cmd_field = op_ext ? EXT_CODE : op_addr[DATA_W-3:0];
    cmd_byte  = {(op_write ? CMD_PFX_WRITE : CMD_PFX_READ), cmd_field};
  end

  // link owns the bus except while the transceiver is talking
  always_comb begin
    link_owns = !(state == ST_RDATA || state == ST_RHOLD || state == ST_ABORT);
  end

  always_comb begin
    ulpi_data_o = '0;
    ulpi_stp    = 1'b0;
    unique case (state)
      ST_CMD:   ulpi_data_o = cmd_byte;
      ST_ADDR:  ulpi_data_o = op_addr;
      ST_WDATA: ulpi_data_o = op_wdata;
      ST_STP:   ulpi_stp    = !ulpi_dir;
      default:  ulpi_data_o = '0;
    endcase
    ulpi_data_oe = link_owns && !ulpi_dir;
  end

  // R4
  stp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ulpi_stp |=> !ulpi_stp);

  // R4
  stp_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ulpi_stp |-> (ulpi_data_o == '0 && ulpi_data_oe));

endmodule

// File: rtl/ulpi_reg_link.sv
module ulpi_reg_link
  import ulpi_reg_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-3:0] EXT_CODE = 'h2F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_addr_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              ulpi_dir,
  input  logic              ulpi_nxt,
  input  logic [DATA_W-1:0] ulpi_data_i,
  output logic [DATA_W-1:0] ulpi_data_o,
  output logic              ulpi_data_oe,
  output logic              ulpi_stp
);

  ulpi_st_e          state;
  logic              accept;
  logic              op_write;
  logic              op_ext;
  logic [DATA_W-1:0] op_addr;
  logic [DATA_W-1:0] op_wdata;

  assign req_ready = (state == ST_IDLE) && !ulpi_dir;
  assign accept    = req_valid && req_ready;

  ulpi_req_hold #(.DATA_W(DATA_W), .EXT_CODE(EXT_CODE)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .ext_addr_en (ext_addr_en),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .op_write    (op_write),
    .op_ext      (op_ext),
    .op_addr     (op_addr),
    .op_wdata    (op_wdata)
  );

  ulpi_reg_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .op_write    (op_write),
    .op_ext      (op_ext),
    .ulpi_dir    (ulpi_dir),
    .ulpi_nxt    (ulpi_nxt),
    .ulpi_data_i (ulpi_data_i),
    .state       (state),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata)
  );

  ulpi_bus_drive #(.DATA_W(DATA_W), .EXT_CODE(EXT_CODE)) u_drive (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state),
    .op_write     (op_write),
    .op_ext       (op_ext),
    .op_addr      (op_addr),
    .op_wdata     (op_wdata),
    .ulpi_dir     (ulpi_dir),
    .ulpi_data_o  (ulpi_data_o),
    .ulpi_data_oe (ulpi_data_oe),
    .ulpi_stp     (ulpi_stp)
  );

  // R1
  accept_starts_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (ulpi_dir || (ulpi_data_oe && ulpi_data_o[DATA_W-1])));

  // R2
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ulpi_data_oe) && ulpi_data_oe && !$past(ulpi_nxt) && !$past(ulpi_dir)
      && !$past(accept) && !$past(ulpi_stp)) |-> $stable(ulpi_data_o));

endmodule

// File: tb/ulpi_reg_link_tb.sv
module ulpi_reg_link_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_addr_en;
  logic       req_valid;
  logic       req_ready;
  logic       req_write;
  logic [7:0] req_addr;
  logic [7:0] req_wdata;
  logic       rsp_valid;
  logic [7:0] rsp_rdata;
  logic       ulpi_dir;
  logic       ulpi_nxt;
  logic [7:0] ulpi_data_i;
  logic [7:0] ulpi_data_o;
  logic       ulpi_data_oe;
  logic       ulpi_stp;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ulpi_reg_link u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_addr_en  (ext_addr_en),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .ulpi_dir     (ulpi_dir),
    .ulpi_nxt     (ulpi_nxt),
    .ulpi_data_i  (ulpi_data_i),
    .ulpi_data_o  (ulpi_data_o),
    .ulpi_data_oe (ulpi_data_oe),
    .ulpi_stp     (ulpi_stp)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // link must hold exp until NXT; NXT is given on the (wait_n+1)th cycle
  task automatic send_byte(input logic [7:0] exp, input int wait_n, input string req);
    for (int i = 0; i <= wait_n; i++) begin
      @(negedge clk);
      chk(ulpi_data_oe && !ulpi_stp && ulpi_data_o == exp, req, "byte held",
          {ulpi_data_oe, ulpi_stp, ulpi_data_o}, {1'b1, 1'b0, exp});
      ulpi_nxt = (i == wait_n);
      @(posedge clk);
      #1 ulpi_nxt = 1'b0;
    end
  endtask

  // PHY takes the bus while exp is driven, then hands it back
  task automatic take_bus(input logic [7:0] exp, input int hold_n);
    @(negedge clk);
    chk(ulpi_data_oe && ulpi_data_o == exp, "R7", "byte before takeover",
        ulpi_data_o, exp);
    ulpi_dir = 1'b1;
    #1 chk(!ulpi_data_oe, "R7", "release on dir", ulpi_data_oe, 0);
    @(posedge clk);
    for (int i = 0; i < hold_n; i++) begin
      @(negedge clk);
      chk(!ulpi_data_oe && !ulpi_stp && !req_ready, "R8", "idle while aborted",
          {ulpi_data_oe, ulpi_stp, req_ready}, 0);
      @(posedge clk);
    end
    @(negedge clk);
    ulpi_dir = 1'b0;
    @(posedge clk);
  endtask

  // abort_at: -1 none, 0 command byte, 1 address/data byte, 9 read data cycle
  task automatic do_op(input bit wr, input logic [7:0] a, input logic [7:0] d,
                       input int abort_at);
    bit         ext;
    logic [7:0] cmd;
    logic [7:0] rval;
    ext  = ext_addr_en && (a >= 8'h2F);
    cmd  = {(wr ? 2'b10 : 2'b11), (ext ? 6'h2F : a[5:0])};
    rval = a ^ 8'h5A;
    @(negedge clk);
    chk(req_ready, "R1", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1 req_valid = 1'b0;
    for (int att = 0; att < 2; att++) begin
      bit ab;
      ab = (att == 0) && (abort_at >= 0);
      if (ab && abort_at == 0) begin take_bus(cmd, 1 + (a % 2)); continue; end
      send_byte(cmd, a % 3, ext ? "R3" : (wr ? "R2" : "R5"));
      if (ext) begin
        if (ab && abort_at == 1) begin take_bus(a, 1); continue; end
        send_byte(a, 1, "R3");
      end
      if (wr) begin
        if (ab && abort_at == 1 && !ext) begin take_bus(d, 2); continue; end
        send_byte(d, (a + 1) % 3, "R2");
        @(negedge clk);
        chk(ulpi_stp && ulpi_data_oe && ulpi_data_o == 8'h00, "R4", "stop strobe",
            {ulpi_stp, ulpi_data_o}, {1'b1, 8'h00});
        @(negedge clk);
        chk(rsp_valid && !ulpi_stp, "R4", "write done pulse",
            {rsp_valid, ulpi_stp}, {1'b1, 1'b0});
        break;
      end else begin
        @(negedge clk);
        chk(ulpi_data_oe && ulpi_data_o == 8'h00 && !rsp_valid, "R5", "idle before turnaround",
            {ulpi_data_oe, ulpi_data_o}, {1'b1, 8'h00});
        ulpi_dir = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ulpi_data_i = rval;
        ulpi_nxt    = ab && (abort_at == 9);
        @(posedge clk);
        #1 ulpi_nxt = 1'b0;
        if (ab && abort_at == 9) begin
          @(negedge clk);
          chk(!ulpi_data_oe && !rsp_valid, "R9", "receive event discarded",
              {ulpi_data_oe, rsp_valid}, 0);
          ulpi_dir    = 1'b0;
          ulpi_data_i = 8'h00;
          @(posedge clk);
          continue;
        end
        @(negedge clk);
        chk(!rsp_valid && !ulpi_data_oe, "R6", "no done while dir high",
            {rsp_valid, ulpi_data_oe}, 0);
        ulpi_dir    = 1'b0;
        ulpi_data_i = 8'h00;
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid && rsp_rdata == rval, "R6", "read data", rsp_rdata, rval);
        break;
      end
    end
    @(negedge clk);
    chk(!rsp_valid, "R6", "done is one cycle", rsp_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_addr_en = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; ulpi_dir = 1'b0; ulpi_nxt = 1'b0; ulpi_data_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(req_ready && ulpi_data_oe && ulpi_data_o == 8'h00 && !ulpi_stp && !rsp_valid,
        "R10", "reset state",
        {req_ready, ulpi_data_oe, ulpi_data_o, ulpi_stp, rsp_valid}, {2'b11, 8'h00, 2'b00});

    // R1: request while DIR high is not taken
    ulpi_dir = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h12;
    #1 chk(!req_ready, "R1", "ready with dir high", req_ready, 0);
    @(posedge clk);
    @(negedge clk);
    ulpi_dir = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    chk(ulpi_data_oe && ulpi_data_o == 8'h00 && req_ready, "R1", "no command started",
        ulpi_data_o, 0);

    // sweep every immediate address, write then read
    for (int a = 0; a < 64; a++) begin
      do_op(1'b1, a[7:0], 8'hC3 ^ a[7:0], -1);
      do_op(1'b0, a[7:0], 8'h00, -1);
    end

    // R3 upper bits ignored without extended addressing
    do_op(1'b1, 8'hC5, 8'h77, -1);
    do_op(1'b0, 8'hB0, 8'h00, -1);

    // R3 extended addressing boundary
    ext_addr_en = 1'b1;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] ea;
      ea = (k == 0) ? 8'h2E : (k == 1) ? 8'h2F : (k == 2) ? 8'h30 :
           (k == 3) ? 8'h3F : (k == 4) ? 8'h80 : 8'hFF;
      do_op(1'b1, ea, ~ea, -1);
      do_op(1'b0, ea, 8'h00, -1);
    end

    // R7 R8 R9 aborts and retries, both addressing forms
    for (int e = 0; e < 2; e++) begin
      ext_addr_en = e[0];
      do_op(1'b1, 8'h04, 8'h5D, 0);
      do_op(1'b1, 8'h41, 8'hA2, 1);
      do_op(1'b0, 8'h16, 8'h00, 0);
      do_op(1'b0, 8'h9C, 8'h00, 1);
      do_op(1'b0, 8'h0A, 8'h00, 9);
      do_op(1'b0, 8'hE7, 8'h00, 9);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule